// File: doc/BRIEF.md
# Center-Aligned PWM Generator with Compare Actions

This block produces two pulse-width-modulated outputs from one 16-bit counter. The counter advances on a tick taken from a power-of-two prescaler. It runs in one of two modes. In down mode it falls from the period value to zero and reloads. In up/down mode it climbs from zero to the period value and falls back, which gives center-aligned pulses. Two compare values are matched against the count. Each output has its own 12-bit action word. For every compare event, and separately for each counting direction, the word chooses whether the output holds, toggles, goes low or goes high.

Software programs the block through a single-cycle register write port. A new period or compare value reaches the working copy only when the counter passes through zero, so a write made mid-period never cuts a pulse short. Each pin stays low until its output-enable bit is set, and both pins go low while the generator is stopped. A typical use is hobby-servo drive: a 20 ms frame with a pulse of 0.9 ms to 2.4 ms, centred at 1.65 ms.

Top module: `pwm_updown_gen`

## Requirements
- R1: After reset, and on every clock edge while the run bit (CTRL bit 0) is clear, the counter is held at zero and both pins are low on the following cycle.
- R2: Register write port map: address 0 CTRL (bit 0 run, bit 1 up/down mode), 1 period LOAD, 2 compare A, 3 compare B, 4 action word of pin A, 5 action word of pin B, 6 output enables (bit 0 pin A, bit 1 pin B), 7 prescaler (bit 0 use-divider, bits 3:1 select s). With use-divider clear, tick_o is high on every clock. With it set, tick_o is high once every 2^(s+1) clocks, so s=5 divides by 64.
- R3: In down mode the counter steps down by one per tick. At zero it reloads LOAD, so the period is LOAD+1 ticks.
- R4: In up/down mode the counter goes from 0 up to LOAD, then back down to 0, for a period of 2*LOAD ticks. It never exceeds the working LOAD.
- R5: Action word fields: bits 5:4 compare-A counting up, 7:6 compare-A counting down, 9:8 compare-B counting up, 11:10 compare-B counting down. Code 0 holds, 1 toggles, 2 drives low, 3 drives high. The output changes on the clock edge of the tick on which the count equals the compare value. On other ticks it holds.
- R6: When compare-A and compare-B events fall on the same tick, a non-zero compare-B code wins over the compare-A code. Either pin may use either compare, so pin A driven by A events and pin B driven by B events have independent duties.
- R7: LOAD, compare A and compare B written while running take effect only at a tick where the count is zero. While stopped, they take effect immediately.
- R8: A pin is low whenever its output-enable bit is clear, whatever its action state.
- R9: Servo timing: with a 781.25 kHz tick (50 MHz divided by 64), down mode with LOAD 15624 gives 20 ms frames. With compare-A counting down set to high, compare B = 0 counting down set to low, and compare A of 703, 1289 or 1875, pin A is high for 703, 1289 or 1875 ticks of each 15625.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| tick_o | output | 1 | Prescaled counter tick |
| pwm_a | output | 1 | PWM pin A |
| pwm_b | output | 1 | PWM pin B |

## Verification
The bench builds the block with its default parameters: a 16-bit counter, an 8-bit prescaler and a 3-bit divider select. These defaults make the full servo frame of 15625 ticks reachable, as is the divide-by-64 tick. The servo pulses are measured with the divider off, so each frame costs 15625 clocks rather than a million. Random short periods, action words and mid-period writes, with the divider set to 2, 4 or 8, exercise direction turn-around, B-over-A priority and the zero-point shadow load against a cycle-level model.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    localparam int ADDR_W = 3;
    localparam int ACT_W  = 12;
    localparam int NCH    = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL  = 3'd0,
        REG_LOAD  = 3'd1,
        REG_CMPA  = 3'd2,
        REG_CMPB  = 3'd3,
        REG_ACTA  = 3'd4,
        REG_ACTB  = 3'd5,
        REG_OEN   = 3'd6,
        REG_PRESC = 3'd7
    } reg_addr_e;

    typedef enum logic [1:0] {
        ACT_KEEP = 2'd0,
        ACT_FLIP = 2'd1,
        ACT_LOW  = 2'd2,
        ACT_HIGH = 2'd3
    } act_e;

    // compare events seen on the current count
    typedef struct packed {
        logic a_up;
        logic a_dn;
        logic b_up;
        logic b_dn;
    } evt_t;

    // compare-B code overrides compare-A code when non-zero
    function automatic act_e pick_action(input logic [ACT_W-1:0] f, input evt_t e);
        act_e ca;
        act_e cb;
        ca = e.a_up ? act_e'(f[5:4])   : (e.a_dn ? act_e'(f[7:6])   : ACT_KEEP);
        cb = e.b_up ? act_e'(f[9:8])   : (e.b_dn ? act_e'(f[11:10]) : ACT_KEEP);
        return (cb != ACT_KEEP) ? cb : ca;
    endfunction

    function automatic logic apply_action(input act_e c, input logic cur);
        logic nxt;
        case (c)
            ACT_FLIP: nxt = ~cur;
            ACT_LOW:  nxt = 1'b0;
            ACT_HIGH: nxt = 1'b1;
            default:  nxt = cur;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
    parameter int PRE_W = 8,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             use_div,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    logic [PRE_W-1:0] pcnt;
    logic [PRE_W-1:0] mask;

    always_ff @(posedge clk) begin
        if (rst) pcnt <= '0;
        else     pcnt <= pcnt + PRE_W'(1);
    end

    // divide by 2^(sel+1): tick when the low sel+1 bits are all ones
    always_comb begin
        mask = (PRE_W'(2) << sel) - PRE_W'(1);
        tick = !use_div || ((pcnt & mask) == mask);
    end
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter
    import pwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             updown,
    input  logic             tick,
    input  logic [CNT_W-1:0] load_p,
    input  logic [CNT_W-1:0] cmpa_p,
    input  logic [CNT_W-1:0] cmpb_p,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] load_w,
    output logic [CNT_W-1:0] cmpa_w,
    output logic [CNT_W-1:0] cmpb_w,
    output evt_t             evt
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic dir_up;
    logic at_zero;
    logic at_top;

    assign at_zero = (cnt == '0);
    assign at_top  = (cnt >= load_w);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            dir_up <= 1'b0;
            load_w <= '0;
            cmpa_w <= '0;
            cmpb_w <= '0;
        end else if (!run) begin
            cnt    <= '0;
            dir_up <= 1'b0;
            load_w <= load_p;
            cmpa_w <= cmpa_p;
            cmpb_w <= cmpb_p;
        end else if (tick) begin
            if (at_zero) begin
                load_w <= load_p;
                cmpa_w <= cmpa_p;
                cmpb_w <= cmpb_p;
                if (updown) begin
                    cnt    <= (load_p != '0) ? ONE : '0;
                    dir_up <= (load_p != '0);
                end else begin
                    cnt    <= load_p;
                    dir_up <= 1'b0;
                end
            end else if (updown && dir_up) begin
                if (at_top) begin
                    cnt    <= cnt - ONE;
                    dir_up <= 1'b0;
                end else begin
                    cnt <= cnt + ONE;
                end
            end else begin
                cnt    <= cnt - ONE;
                dir_up <= 1'b0;
            end
        end
    end

    always_comb begin
        evt.a_up = (cnt == cmpa_w) &&  dir_up;
        evt.a_dn = (cnt == cmpa_w) && !dir_up;
        evt.b_up = (cnt == cmpb_w) &&  dir_up;
        evt.b_dn = (cnt == cmpb_w) && !dir_up;
    end
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
    import pwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             tick,
    input  evt_t             evt,
    input  logic [ACT_W-1:0] fields,
    input  logic             oen,
    output logic             state,
    output logic             pin
);
    always_ff @(posedge clk) begin
        if (rst)       state <= 1'b0;
        else if (!run) state <= 1'b0;
        else if (tick) state <= apply_action(pick_action(fields, evt), state);
    end

    assign pin = state & oen;
endmodule

// File: rtl/pwm_updown_gen.sv
module pwm_updown_gen
    import pwm_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int PRE_W  = 8,
    parameter int SEL_W  = 3,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              tick_o,
    output logic              pwm_a,
    output logic              pwm_b
);
    // programmed values
    logic             run_q;
    logic             ud_q;
    logic [CNT_W-1:0] load_q;
    logic [CNT_W-1:0] cmpa_q;
    logic [CNT_W-1:0] cmpb_q;
    logic [ACT_W-1:0] act_q [NCH];
    logic [NCH-1:0]   oen_q;
    logic             use_div_q;
    logic [SEL_W-1:0] sel_q;

    // datapath
    logic             tick;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] load_w;
    logic [CNT_W-1:0] cmpa_w;
    logic [CNT_W-1:0] cmpb_w;
    evt_t             evt;
    logic [NCH-1:0]   ch_state;
    logic [NCH-1:0]   ch_pin;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q     <= 1'b0;
            ud_q      <= 1'b0;
            load_q    <= '0;
            cmpa_q    <= '0;
            cmpb_q    <= '0;
            oen_q     <= '0;
            use_div_q <= 1'b0;
            sel_q     <= '0;
            for (int i = 0; i < NCH; i++) act_q[i] <= '0;
        end else if (wr_en) begin
            case (reg_addr_e'(wr_addr))
                REG_CTRL: begin
                    run_q <= wr_data[0];
                    ud_q  <= wr_data[1];
                end
                REG_LOAD:  load_q   <= wr_data[CNT_W-1:0];
                REG_CMPA:  cmpa_q   <= wr_data[CNT_W-1:0];
                REG_CMPB:  cmpb_q   <= wr_data[CNT_W-1:0];
                REG_ACTA:  act_q[0] <= wr_data[ACT_W-1:0];
                REG_ACTB:  act_q[1] <= wr_data[ACT_W-1:0];
                REG_OEN:   oen_q    <= wr_data[NCH-1:0];
                REG_PRESC: begin
                    use_div_q <= wr_data[0];
                    sel_q     <= wr_data[SEL_W:1];
                end
                default: ;
            endcase
        end
    end

    pwm_prescaler #(.PRE_W(PRE_W), .SEL_W(SEL_W)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .use_div (use_div_q),
        .sel     (sel_q),
        .tick    (tick)
    );

    pwm_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .run    (run_q),
        .updown (ud_q),
        .tick   (tick),
        .load_p (load_q),
        .cmpa_p (cmpa_q),
        .cmpb_p (cmpb_q),
        .cnt    (cnt),
        .load_w (load_w),
        .cmpa_w (cmpa_w),
        .cmpb_w (cmpb_w),
        .evt    (evt)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        pwm_channel u_ch (
            .clk    (clk),
            .rst    (rst),
            .run    (run_q),
            .tick   (tick),
            .evt    (evt),
            .fields (act_q[g]),
            .oen    (oen_q[g]),
            .state  (ch_state[g]),
            .pin    (ch_pin[g])
        );
    end

    assign tick_o = tick;
    assign pwm_a  = ch_pin[0];
    assign pwm_b  = ch_pin[1];
endmodule

// File: rtl/pwm_updown_chk.sv
module pwm_updown_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             run,
    input logic             updown,
    input logic             tick,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] load_w,
    input logic [CNT_W-1:0] cmpa_w,
    input logic [CNT_W-1:0] cmpb_w,
    input logic             st_a,
    input logic             st_b,
    input logic             pwm_a,
    input logic             pwm_b
);
    assert_idle_low_R1: assert property (@(posedge clk) disable iff (rst)
        !run |=> (!pwm_a && !pwm_b));

    assert_down_step_R3: assert property (@(posedge clk) disable iff (rst)
        (run && !updown && tick && cnt != '0) |=> (cnt == $past(cnt) - CNT_W'(1)));

    assert_cnt_bounded_R4: assert property (@(posedge clk) disable iff (rst)
        cnt <= load_w);

    assert_hold_no_match_R5: assert property (@(posedge clk) disable iff (rst)
        (run && (!tick || (cnt != cmpa_w && cnt != cmpb_w))) |=> ($stable(st_a) && $stable(st_b)));

    assert_shadow_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (run && !(tick && cnt == '0)) |=> ($stable(load_w) && $stable(cmpa_w) && $stable(cmpb_w)));
endmodule

bind pwm_updown_gen pwm_updown_chk #(.CNT_W(CNT_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .run    (run_q),
    .updown (ud_q),
    .tick   (tick),
    .cnt    (cnt),
    .load_w (load_w),
    .cmpa_w (cmpa_w),
    .cmpb_w (cmpb_w),
    .st_a   (ch_state[0]),
    .st_b   (ch_state[1]),
    .pwm_a  (pwm_a),
    .pwm_b  (pwm_b)
);

// File: tb/sim_pwm_updown_gen.sv
module sim_pwm_updown_gen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        tick_o, pwm_a, pwm_b;

    int n_chk = 0;
    int n_fail = 0;
    int hi_a = 0, hi_b = 0, tk_cnt = 0;
    bit done = 1'b0;

    // reference state built from the requirements
    bit          m_run, m_ud, m_use, m_dir, m_oa, m_ob;
    logic [2:0]  m_sel;
    logic [1:0]  m_oen;
    logic [7:0]  m_pc;
    logic [15:0] m_load, m_ca, m_cb, m_cnt, m_lw, m_aw, m_bw;
    logic [11:0] m_acta, m_actb;

    always #10 clk = ~clk;

    pwm_updown_gen u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .tick_o(tick_o), .pwm_a(pwm_a), .pwm_b(pwm_b)
    );

    function automatic logic [1:0] code_for(logic [11:0] f, bit au, bit ad, bit bu, bit bd);
        logic [1:0] ca, cb;
        ca = au ? f[5:4] : (ad ? f[7:6]   : 2'd0);
        cb = bu ? f[9:8] : (bd ? f[11:10] : 2'd0);
        return (cb != 2'd0) ? cb : ca;
    endfunction

    function automatic bit next_out(logic [1:0] c, bit cur);
        case (c)
            2'd1: return ~cur;
            2'd2: return 1'b0;
            2'd3: return 1'b1;
            default: return cur;
        endcase
    endfunction

    function automatic bit m_tick();
        logic [7:0] mask;
        mask = (8'd2 << m_sel) - 8'd1;
        return !m_use || ((m_pc & mask) == mask);
    endfunction

    task automatic model_step();
        bit tk, au, ad, bu, bd;
        if (rst) begin
            {m_run, m_ud, m_use, m_dir, m_oa, m_ob} = '0;
            m_sel = '0; m_oen = '0; m_pc = '0;
            m_load = '0; m_ca = '0; m_cb = '0; m_cnt = '0;
            m_lw = '0; m_aw = '0; m_bw = '0; m_acta = '0; m_actb = '0;
            return;
        end
        tk = m_tick();
        m_pc = m_pc + 8'd1;
        if (!m_run) begin
            m_cnt = '0; m_dir = 0; m_oa = 0; m_ob = 0;
            m_lw = m_load; m_aw = m_ca; m_bw = m_cb;
        end else if (tk) begin
            au = (m_cnt == m_aw) && m_dir;  ad = (m_cnt == m_aw) && !m_dir;
            bu = (m_cnt == m_bw) && m_dir;  bd = (m_cnt == m_bw) && !m_dir;
            m_oa = next_out(code_for(m_acta, au, ad, bu, bd), m_oa);
            m_ob = next_out(code_for(m_actb, au, ad, bu, bd), m_ob);
            if (m_cnt == 0) begin
                m_lw = m_load; m_aw = m_ca; m_bw = m_cb;
                if (m_ud) begin
                    m_dir = (m_load != 0);
                    m_cnt = (m_load != 0) ? 16'd1 : 16'd0;
                end else begin
                    m_cnt = m_load; m_dir = 0;
                end
            end else if (m_ud && m_dir) begin
                if (m_cnt >= m_lw) begin m_cnt = m_cnt - 1; m_dir = 0; end
                else m_cnt = m_cnt + 1;
            end else begin
                m_cnt = m_cnt - 1; m_dir = 0;
            end
        end
        if (wr_en) begin
            case (wr_addr)
                3'd0: begin m_run = wr_data[0]; m_ud = wr_data[1]; end
                3'd1: m_load = wr_data;
                3'd2: m_ca = wr_data;
                3'd3: m_cb = wr_data;
                3'd4: m_acta = wr_data[11:0];
                3'd5: m_actb = wr_data[11:0];
                3'd6: m_oen = wr_data[1:0];
                default: begin m_use = wr_data[0]; m_sel = wr_data[3:1]; end
            endcase
        end
    endtask

    task automatic chk(bit ok, string tag, int got, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
        end
    endtask

    // pins follow R5/R6/R7 behaviour gated by R8 enables; tick per R2
    task automatic compare_all();
        bit ea, eb;
        ea = m_oa & m_oen[0];
        eb = m_ob & m_oen[1];
        chk(pwm_a == ea, "R5/R6/R7 pwm_a vs model", int'(pwm_a), int'(ea));
        chk(pwm_b == eb, "R5/R6/R7 pwm_b vs model", int'(pwm_b), int'(eb));
        chk(tick_o == m_tick(), "R2 tick_o vs model", int'(tick_o), int'(m_tick()));
        if (pwm_a) hi_a++;
        if (pwm_b) hi_b++;
        if (tick_o) tk_cnt++;
    endtask

    task automatic step(bit we, logic [2:0] a, logic [15:0] d);
        wr_en = we; wr_addr = a; wr_data = d;
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
        wr_en = 1'b0;
    endtask

    task automatic wr(logic [2:0] a, logic [15:0] d);
        step(1'b1, a, d);
    endtask

    task automatic idle(int n);
        repeat (n) step(1'b0, 3'd0, 16'd0);
    endtask

    task automatic measure(int n);
        hi_a = 0; hi_b = 0; tk_cnt = 0;
        idle(n);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog (all requirements) got=timeout exp=finished");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        rst = 1'b1;
        repeat (3) step(1'b0, 3'd0, 16'd0);
        rst = 1'b0;
        // R1 reset state: pins low, R2 tick every clock with divider off
        chk(pwm_a == 0 && pwm_b == 0, "R1 pins low after reset", int'({pwm_a, pwm_b}), 0);
        chk(tick_o == 1, "R2 tick every clock after reset", int'(tick_o), 1);

        // R4/R5 center-aligned: LOAD 10, A up-high/down-low at 4, B from compare B at 7
        wr(3'd1, 16'd10); wr(3'd2, 16'd4); wr(3'd3, 16'd7);
        wr(3'd4, 16'h0B0); wr(3'd5, 16'hB00); wr(3'd6, 16'd3);
        wr(3'd0, 16'd3);
        idle(45);
        measure(20);
        chk(hi_a == 12, "R4 up/down duty of pin A over 20 ticks", hi_a, 12);
        chk(hi_b == 6, "R6 independent duty of pin B from compare B", hi_b, 6);

        // R8: pin B disabled
        wr(3'd6, 16'd1);
        measure(20);
        chk(hi_b == 0, "R8 disabled pin B stays low", hi_b, 0);
        chk(hi_a == 12, "R8 pin A unaffected", hi_a, 12);

        // R1: stop
        wr(3'd0, 16'd0);
        measure(10);
        chk(hi_a == 0 && hi_b == 0, "R1 stopped pins low", hi_a + hi_b, 0);

        // R2: divide by 64, then off
        wr(3'd7, 16'h000B);
        measure(640);
        chk(tk_cnt == 10, "R2 divide-by-64 tick count over 640 clocks", tk_cnt, 10);
        wr(3'd7, 16'h0000);

        // R3/R5 down mode, toggle at zero, LOAD 5 -> period 6
        wr(3'd1, 16'd5); wr(3'd2, 16'd0); wr(3'd4, 16'h040); wr(3'd6, 16'd1);
        wr(3'd0, 16'd1);
        idle(10);
        measure(24);
        chk(hi_a == 12, "R3 down-mode period 6 with toggle code", hi_a, 12);

        // R9 servo frames: 15625 ticks, pulse = compare A ticks
        wr(3'd0, 16'd0);
        wr(3'd1, 16'd15624); wr(3'd2, 16'd1289); wr(3'd3, 16'd0);
        wr(3'd4, 16'h8C0); wr(3'd6, 16'd1);
        wr(3'd0, 16'd1);
        idle(15630);
        measure(15625);
        chk(hi_a == 1289, "R9 servo centre pulse 1.65 ms", hi_a, 1289);
        wr(3'd2, 16'd1875);
        idle(15630);
        measure(15625);
        chk(hi_a == 1875, "R9 servo pulse 2.4 ms after zero-point load (R7)", hi_a, 1875);
        wr(3'd2, 16'd703);
        idle(15630);
        measure(15625);
        chk(hi_a == 703, "R9 servo pulse 0.9 ms", hi_a, 703);

        // random configurations with mid-period writes, checked every cycle
        for (int r = 0; r < 30; r++) begin
            wr(3'd0, 16'd0);
            wr(3'd1, 16'($urandom_range(3, 30)));
            wr(3'd2, 16'($urandom_range(0, 31)));
            wr(3'd3, 16'($urandom_range(0, 31)));
            wr(3'd4, 16'($urandom_range(0, 4095)));
            wr(3'd5, 16'($urandom_range(0, 4095)));
            wr(3'd6, 16'($urandom_range(0, 3)));
            wr(3'd7, 16'($urandom_range(0, 5)));
            wr(3'd0, 16'($urandom_range(0, 1) * 2 + 1));
            for (int c = 0; c < 200; c++) begin
                if ($urandom_range(0, 19) == 0)
                    wr(3'($urandom_range(1, 5)), 16'($urandom_range(0, 31)));
                else
                    idle(1);
            end
        end
        finish_run();
    end
endmodule